// File: doc/BRIEF.md
# Fractional Audio Clock Divider

This block turns a fast source clock into two rate enables for an audio serial port. The first, the master tick, fires once per master period. A period normally lasts N source cycles, where N is the integer divisor. To reach a non-integer ratio N + b/a, the block lengthens selected periods by one source cycle. It does this from a compact pattern encoding of three counts (x, y, z) and an inversion flag, rather than from an accumulator. The second enable, the bit tick, fires on every (m+1)-th master tick, where m is a small integer field.

Software works out x, y, z and the flag from the fraction b/a. If b is zero, all three counts are zero. If b > floor(a/2), then z = a-b, x = floor(a/(a-b))-1, y = a mod (a-b) and the flag is 1. Otherwise z = b, x = floor(a/b)-1, y = (a mod b)+1 and the flag is 0. The settings on the inputs are only sampled on an update strobe. They are switched in at a master-period boundary, so every period runs under exactly one setting.

Top module: `audio_frac_clkdiv`

## Requirements
- R1: While reset is asserted both ticks are low. After reset the block divides by 2 with no fraction and a bit ratio of 1 (bit tick on every master tick).
- R2: With z = 0, every master period lasts exactly N source cycles. The master tick is high for one cycle only, the last cycle of each period.
- R3: A divisor value of 0 or 1 behaves as 2.
- R4: Every master period lasts N or N+1 source cycles.
- R5: With the flag at 0 and z > 0, a frame starts with z groups of x+1 periods. Only the first period of each group is long (N+1). The groups are followed by y-1 short periods.
- R6: With the flag at 1 and z > 0, a frame starts with z groups of x+1 periods. Only the first period of each group is short (N). The groups are followed by y long periods. Frames repeat back to back.
- R7: For counts derived from a and b as stated above, a frame holds a periods and lasts exactly N*a + b source cycles.
- R8: The bit tick is only ever high together with the master tick. It marks every (m+1)-th master tick, counted from the last setting switch-in.
- R9: A strobe captures all setting inputs. They take effect at the first master tick seen in a cycle after the strobe cycle. The period in progress keeps its old length. The next period starts a new frame, and the bit count restarts from zero.
- R10: Changing the setting inputs without a strobe has no effect on either tick.
- R11: The largest divisor, 511, gives a 511-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | One-cycle strobe that captures the setting inputs |
| mdiv_i | input | MDIV_W | Integer master divisor N |
| frac_x_i | input | FRAC_W | Pattern count x (periods per group minus one) |
| frac_y_i | input | FRAC_W | Pattern count y (tail length control) |
| frac_z_i | input | FRAC_W | Pattern count z (groups per frame, 0 = no fraction) |
| frac_inv_i | input | 1 | Pattern inversion flag |
| bdiv_i | input | BDIV_W | Bit ratio minus one (m) |
| mclk_tick_o | output | 1 | Master tick, one cycle per master period |
| bclk_tick_o | output | 1 | Bit tick, on every (m+1)-th master tick |

## Verification
The bench sweeps every fraction b/a with a up to 8, at three divisors. For each one it checks the length of every period against the group-and-tail pattern, and the exact total length of two consecutive frames. A wrong tail length or an off-by-one group count would still give plausible single periods but break the frame total. A wrong inversion would swap the short and long positions. The bench also strobes a new divisor in the middle of a period to catch a design that cuts the running period short. It changes inputs without a strobe to catch a design that leaks them through. It checks the clamp of 0 and 1 and the 511 ceiling. Finally it counts master ticks between bit ticks, which exposes a bit counter that is not restarted when a setting is switched in.

// File: rtl/acd_pkg.sv
package acd_pkg;
   // smallest usable master divisor; smaller settings are raised to it
   localparam int MIN_DIV = 2;

   typedef enum logic {
      PH_GROUP = 1'b0,
      PH_TAIL  = 1'b1
   } acd_phase_e;
endpackage

// File: rtl/acd_cfg_hold.sv
// Setting capture: strobe loads a pending copy, a period boundary switches it in.
module acd_cfg_hold #(
   parameter int              W       = 8,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic         upd_i,
   input  logic [W-1:0] cfg_i,
   input  logic         bound_i,
   output logic [W-1:0] act_o,
   output logic         apply_o
);
   logic [W-1:0] pend_q;
   logic         pend_v_q;

   assign apply_o = bound_i & pend_v_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         pend_q   <= RST_VAL;
         pend_v_q <= 1'b0;
         act_o    <= RST_VAL;
      end else begin
         if (upd_i) begin
            pend_q   <= cfg_i;
            pend_v_q <= 1'b1;
         end else if (apply_o) begin
            pend_v_q <= 1'b0;
         end
         if (apply_o) begin
            act_o <= pend_q;
         end
      end
   end
endmodule

// File: rtl/acd_frac_seq.sv
// Walks the group/tail pattern and flags which master periods are stretched.
module acd_frac_seq #(
   parameter int FW = 9
) (
   input  logic          clk_i,
   input  logic          rst_n_i,
   input  logic          tick_i,
   input  logic          restart_i,
   input  logic [FW-1:0] x_i,
   input  logic [FW-1:0] y_i,
   input  logic [FW-1:0] z_i,
   input  logic          inv_i,
   output logic          extra_o
);
   import acd_pkg::*;

   acd_phase_e    ph_q;
   logic [FW-1:0] pos_q, grp_q, tcnt_q;
   logic [FW:0]   tail_len;
   logic          tail_empty, tail_last, first_in_grp;

   always_comb begin
      tail_len     = inv_i ? {1'b0, y_i} : ({1'b0, y_i} - (FW+1)'(1));
      tail_empty   = inv_i ? (y_i == '0) : (y_i <= FW'(1));
      tail_last    = (({1'b0, tcnt_q} + (FW+1)'(1)) == tail_len);
      first_in_grp = (pos_q == '0);
      if (z_i == '0) begin
         extra_o = 1'b0;
      end else if (ph_q == PH_GROUP) begin
         extra_o = inv_i ? ~first_in_grp : first_in_grp;
      end else begin
         extra_o = inv_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         ph_q   <= PH_GROUP;
         pos_q  <= '0;
         grp_q  <= '0;
         tcnt_q <= '0;
      end else if (tick_i) begin
         if (restart_i || (z_i == '0)) begin
            ph_q   <= PH_GROUP;
            pos_q  <= '0;
            grp_q  <= '0;
            tcnt_q <= '0;
         end else if (ph_q == PH_GROUP) begin
            if (pos_q == x_i) begin
               pos_q <= '0;
               if (grp_q == (z_i - FW'(1))) begin
                  grp_q  <= '0;
                  tcnt_q <= '0;
                  ph_q   <= tail_empty ? PH_GROUP : PH_TAIL;
               end else begin
                  grp_q <= grp_q + FW'(1);
               end
            end else begin
               pos_q <= pos_q + FW'(1);
            end
         end else begin
            if (tail_last) begin
               ph_q   <= PH_GROUP;
               tcnt_q <= '0;
            end else begin
               tcnt_q <= tcnt_q + FW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/acd_period_cnt.sv
// Counts source cycles of one master period (N or N+1) and marks its last cycle.
module acd_period_cnt #(
   parameter int DIV_W = 9
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             extra_i,
   output logic             tick_o
);
   localparam int CW = DIV_W + 1;

   logic [CW-1:0] n_eff, last, cnt_q;

   always_comb begin
      n_eff  = (div_i < DIV_W'(acd_pkg::MIN_DIV)) ? CW'(acd_pkg::MIN_DIV) : {1'b0, div_i};
      last   = n_eff - CW'(1) + {{DIV_W{1'b0}}, extra_i};
      tick_o = (cnt_q == last);
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)    cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/acd_bit_div.sv
// Integer divider on master ticks producing the bit tick.
module acd_bit_div #(
   parameter int BW = 6
) (
   input  logic          clk_i,
   input  logic          rst_n_i,
   input  logic          mtick_i,
   input  logic          restart_i,
   input  logic [BW-1:0] ratio_i,
   output logic          btick_o
);
   logic [BW-1:0] cnt_q;
   logic          wrap;

   assign wrap    = (cnt_q == ratio_i);
   assign btick_o = mtick_i & wrap;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cnt_q <= '0;
      end else if (mtick_i) begin
         if (restart_i || wrap) cnt_q <= '0;
         else                   cnt_q <= cnt_q + BW'(1);
      end
   end
endmodule

// File: rtl/audio_frac_clkdiv.sv
module audio_frac_clkdiv #(
   parameter int MDIV_W = 9,
   parameter int FRAC_W = 9,
   parameter int BDIV_W = 6,
   parameter bit BCK_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              upd_i,
   input  logic [MDIV_W-1:0] mdiv_i,
   input  logic [FRAC_W-1:0] frac_x_i,
   input  logic [FRAC_W-1:0] frac_y_i,
   input  logic [FRAC_W-1:0] frac_z_i,
   input  logic              frac_inv_i,
   input  logic [BDIV_W-1:0] bdiv_i,
   output logic              mclk_tick_o,
   output logic              bclk_tick_o
);
   localparam int CFG_W = MDIV_W + 3*FRAC_W + 1 + BDIV_W;
   localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(acd_pkg::MIN_DIV) << (CFG_W - MDIV_W);

   if (MDIV_W < 2 || MDIV_W > 16) begin : g_bad_mdiv
      $error("MDIV_W out of range");
   end
   if (FRAC_W < 1 || FRAC_W > 16) begin : g_bad_frac
      $error("FRAC_W out of range");
   end
   if (BDIV_W < 1 || BDIV_W > 16) begin : g_bad_bdiv
      $error("BDIV_W out of range");
   end

   logic [CFG_W-1:0]  cfg_in, act_cfg;
   logic [MDIV_W-1:0] act_mdiv;
   logic [FRAC_W-1:0] act_x, act_y, act_z;
   logic              act_inv;
   logic [BDIV_W-1:0] act_bdiv;
   logic              apply, extra, mtick;

   assign cfg_in = {mdiv_i, frac_x_i, frac_y_i, frac_z_i, frac_inv_i, bdiv_i};
   assign {act_mdiv, act_x, act_y, act_z, act_inv, act_bdiv} = act_cfg;

   acd_cfg_hold #(.W(CFG_W), .RST_VAL(CFG_RST)) hold_i (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .upd_i   (upd_i),
      .cfg_i   (cfg_in),
      .bound_i (mtick),
      .act_o   (act_cfg),
      .apply_o (apply)
   );

   acd_frac_seq #(.FW(FRAC_W)) seq_i (
      .clk_i     (clk_i),
      .rst_n_i   (rst_n_i),
      .tick_i    (mtick),
      .restart_i (apply),
      .x_i       (act_x),
      .y_i       (act_y),
      .z_i       (act_z),
      .inv_i     (act_inv),
      .extra_o   (extra)
   );

   acd_period_cnt #(.DIV_W(MDIV_W)) per_i (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .div_i   (act_mdiv),
      .extra_i (extra),
      .tick_o  (mtick)
   );

   assign mclk_tick_o = mtick;

   if (BCK_EN) begin : g_bck
      acd_bit_div #(.BW(BDIV_W)) bdiv_u (
         .clk_i     (clk_i),
         .rst_n_i   (rst_n_i),
         .mtick_i   (mtick),
         .restart_i (apply),
         .ratio_i   (act_bdiv),
         .btick_o   (bclk_tick_o)
      );
   end else begin : g_no_bck
      assign bclk_tick_o = mtick;
   end
endmodule

// File: rtl/acd_checker.sv
module acd_checker #(
   parameter int MDIV_W = 9,
   parameter int FRAC_W = 9
) (
   input logic              clk_i,
   input logic              rst_n_i,
   input logic              mclk_tick_o,
   input logic              bclk_tick_o,
   input logic [MDIV_W-1:0] act_mdiv,
   input logic [FRAC_W-1:0] act_z
);
   localparam int GW = MDIV_W + 2;

   logic [GW-1:0] gap_q, len_now, n_eff;

   assign len_now = gap_q + GW'(1);
   assign n_eff   = (act_mdiv < MDIV_W'(2)) ? GW'(2) : GW'(act_mdiv);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)         gap_q <= '0;
      else if (mclk_tick_o) gap_q <= '0;
      else                  gap_q <= gap_q + GW'(1);
   end

   AST_QUIET_AFTER_RESET: assert property (@(posedge clk_i) $rose(rst_n_i) |-> (!mclk_tick_o && !bclk_tick_o)); // R1
   AST_INT_EXACT: assert property (@(posedge clk_i) disable iff (!rst_n_i) (mclk_tick_o && act_z == '0) |-> (len_now == n_eff)); // R2
   AST_MIN_SPACING: assert property (@(posedge clk_i) disable iff (!rst_n_i) mclk_tick_o |=> !mclk_tick_o); // R3
   AST_PERIOD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i) mclk_tick_o |-> (len_now >= n_eff && len_now <= n_eff + GW'(1))); // R4
   AST_BCK_ON_MCLK: assert property (@(posedge clk_i) disable iff (!rst_n_i) bclk_tick_o |-> mclk_tick_o); // R8
   AST_SWITCH_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_n_i) !mclk_tick_o |=> ($stable(act_mdiv) && $stable(act_z))); // R9
endmodule

bind audio_frac_clkdiv acd_checker #(.MDIV_W(MDIV_W), .FRAC_W(FRAC_W)) chk_i (
   .clk_i       (clk_i),
   .rst_n_i     (rst_n_i),
   .mclk_tick_o (mclk_tick_o),
   .bclk_tick_o (bclk_tick_o),
   .act_mdiv    (act_mdiv),
   .act_z       (act_z)
);

// File: tb/audio_frac_clkdiv_tb.sv
module audio_frac_clkdiv_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_LIMIT = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       upd = 1'b0;
   logic [8:0] mdiv = 9'd2;
   logic [8:0] fx = '0, fy = '0, fz = '0;
   logic       finv = 1'b0;
   logic [5:0] bdiv = '0;
   logic       mtick, btick;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   audio_frac_clkdiv dut_i (
      .clk_i       (clk),
      .rst_n_i     (rst_n),
      .upd_i       (upd),
      .mdiv_i      (mdiv),
      .frac_x_i    (fx),
      .frac_y_i    (fy),
      .frac_z_i    (fz),
      .frac_inv_i  (finv),
      .bdiv_i      (bdiv),
      .mclk_tick_o (mtick),
      .bclk_tick_o (btick)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WDOG_LIMIT) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<=%0d", cyc, WDOG_LIMIT);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // pattern counts from a and b, per the stated encoding rule
   task automatic encode(input int a, input int b, output int x, output int y, output int z, output int inv);
      if (b == 0) begin
         x = 0; y = 0; z = 0; inv = 0;
      end else if (b > a/2) begin
         z = a - b; x = a/(a-b) - 1; y = a % (a-b); inv = 1;
      end else begin
         z = b; x = a/b - 1; y = (a % b) + 1; inv = 0;
      end
   endtask

   function automatic int long_at(input int p, input int x, input int z, input int inv);
      bit first;
      if (z == 0) return 0;
      if (p < z*(x+1)) begin
         first = ((p % (x+1)) == 0);
         return (inv != 0) ? int'(!first) : int'(first);
      end
      return inv;
   endfunction

   // strobe settings in, then wait at the tick that switches them in
   task automatic program_cfg(input int n, input int x, input int y, input int z, input int inv, input int bd);
      @(negedge clk);
      mdiv = 9'(n); fx = 9'(x); fy = 9'(y); fz = 9'(z); finv = inv[0]; bdiv = 6'(bd);
      upd = 1'b1;
      @(negedge clk);
      upd = 1'b0;
      while (!mtick) @(negedge clk);
   endtask

   task automatic period(output int len);
      len = 0;
      do begin
         @(negedge clk);
         len++;
      end while (!mtick);
   endtask

   task automatic ticks_to_bck(output int k);
      k = 0;
      do begin
         @(negedge clk);
         if (mtick) k++;
      end while (!(mtick && btick));
   endtask

   initial begin
      int len, tot, k, x, y, z, inv, lo, hi;
      int nlist[3];
      nlist = '{2, 3, 5};

      // R1: quiet during reset, then divide by 2 with bit tick on every master tick
      repeat (4) begin
         @(negedge clk);
         chk(!mtick && !btick, "R1 reset quiet", int'(mtick) + int'(btick), 0);
      end
      rst_n = 1'b1;
      while (!mtick) @(negedge clk);
      chk(btick, "R1 default bit ratio", int'(btick), 1);
      period(len);
      chk(len == 2, "R1 default period", len, 2);

      // R2/R5/R6/R7/R4: sweep all fractions b/a, a up to 8
      foreach (nlist[ni]) begin
         for (int a = 2; a <= 8; a++) begin
            for (int b = 0; b < a; b++) begin
               encode(a, b, x, y, z, inv);
               program_cfg(nlist[ni], x, y, z, inv, 0);
               for (int f = 0; f < 2; f++) begin
                  tot = 0; lo = 1 << 20; hi = 0;
                  for (int p = 0; p < a; p++) begin
                     period(len);
                     tot += len;
                     if (len < lo) lo = len;
                     if (len > hi) hi = len;
                     if (b == 0)
                        chk(len == nlist[ni], "R2 integer period", len, nlist[ni]);
                     else if (inv != 0)
                        chk(len == nlist[ni] + long_at(p, x, z, inv), "R6 inverted pattern", len, nlist[ni] + long_at(p, x, z, inv));
                     else
                        chk(len == nlist[ni] + long_at(p, x, z, inv), "R5 plain pattern", len, nlist[ni] + long_at(p, x, z, inv));
                  end
                  chk(lo >= nlist[ni] && hi <= nlist[ni] + 1, "R4 period range", hi, nlist[ni] + 1);
                  chk(tot == nlist[ni]*a + b, "R7 frame length", tot, nlist[ni]*a + b);
               end
            end
         end
      end

      // R3: divisors 0 and 1 act as 2 (fraction 1/3 -> frame of 7)
      for (int n = 0; n < 2; n++) begin
         encode(3, 1, x, y, z, inv);
         program_cfg(n, x, y, z, inv, 0);
         tot = 0;
         for (int p = 0; p < 3; p++) begin
            period(len);
            tot += len;
         end
         chk(tot == 7, "R3 clamp", tot, 7);
      end

      // R11: largest divisor, integer and with half a cycle of fraction
      program_cfg(511, 0, 0, 0, 0, 0);
      period(len);
      chk(len == 511, "R11 max period", len, 511);
      encode(2, 1, x, y, z, inv);
      program_cfg(511, x, y, z, inv, 0);
      period(len); tot = len; period(len); tot += len;
      chk(tot == 1023, "R11 max with fraction", tot, 1023);

      // R8: bit tick every m+1 master ticks, counted from switch-in
      program_cfg(3, 0, 0, 0, 0, 3);
      ticks_to_bck(k);
      chk(k == 4, "R8 first bit tick", k, 4);
      ticks_to_bck(k);
      chk(k == 4, "R8 bit spacing", k, 4);

      // R9: mid-period strobe keeps the running period and restarts bit count
      program_cfg(7, 0, 0, 0, 0, 5);
      k = 0;
      do begin
         @(negedge clk);
         k++;
         if (k == 2) begin
            mdiv = 9'd3; bdiv = 6'd2; upd = 1'b1;
         end
         if (k == 3) upd = 1'b0;
      end while (!mtick);
      chk(k == 7, "R9 running period kept", k, 7);
      period(len);
      chk(len == 3, "R9 new period", len, 3);
      k = 1;
      while (!btick) begin
         period(len);
         k++;
      end
      chk(k == 3, "R9 bit count restart", k, 3);

      // R10: inputs changed with no strobe are ignored
      program_cfg(4, 0, 0, 0, 0, 0);
      @(negedge clk);
      mdiv = 9'd9; bdiv = 6'd7; fz = 9'd1; fx = 9'd0; fy = 9'd1;
      while (!mtick) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         period(len);
         chk(len == 4, "R10 period unchanged", len, 4);
         chk(btick, "R10 bit ratio unchanged", int'(btick), 1);
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule